// File: doc/BRIEF.md
# Cascaded Interrupt Cause and Mask Controller

This block collects ninety-six interrupt sources into three groups of thirty-two and presents them to a processor as one level interrupt line plus a vector register that names the source to service. Two groups are main groups whose cause bits follow level inputs from internal units. The third is an auxiliary port group whose bits latch rising edges and hold until software clears them. The pending state of the port group folds into four summary bits of the upper main group, so the port group reaches the processor through a second level of selection.

Each group has a cause register and a mask register on a small register bus. The bus writes on a strobe and reads combinationally. Only bits inside a fixed per-group filter take part in selection. Software reads the vector register, services the named source, and for port sources clears the cause bit by writing a word that is zero only in that bit position.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset the registers read as follows. Low and port cause: 0. Upper cause: 0. Low mask: 0. Port mask: 0. Upper mask: 0x0f000000. Vector: 0x0000007F. The interrupt output is 0. Register addresses: 0 low cause, 1 upper cause, 2 port cause, 3 low mask, 4 upper mask, 5 port mask, 6 vector.
- R2: Each low cause bit equals its source input as sampled at the previous clock edge. The upper cause bits outside 24..27 behave the same way.
- R3: The vector register reads {valid at bit 7, number at bits 6:0}. If any bit of low cause AND low mask AND 0x3dfffffe is set, the vector is valid and the number is the highest such bit index.
- R4: A cause bit outside its group filter is never selected and never drives the interrupt output, even when its mask bit is 1. The low filter is 0x3dfffffe and the upper filter is 0x0f000db7.
- R5: When the low group has a selectable bit, it wins over the upper group.
- R6: With no selectable low bit, take the highest index k set in upper cause AND upper mask AND 0x0f000db7. If k is below 24, the vector number is 32+k.
- R7: A port cause bit is set by a rising edge of its input. It stays set after the input falls, until it is cleared by a write.
- R8: Upper cause bit 24+j reads as the OR of port cause bits 8j..8j+7. The source inputs at upper bits 24..27 are ignored. If a summary bit wins the upper selection, the vector number is 64 plus the highest set bit of port cause AND port mask.
- R9: The vector reads 0x7F (valid 0) in two cases. The first is when nothing is selectable in the low or upper group. The second is when a summary bit wins but no port bit is both pending and enabled.
- R10: A write to the port cause register clears each bit written as 0 and keeps each bit written as 1. A rising edge in the same cycle as a clear of that bit leaves the bit set.
- R11: The interrupt output is registered. It is the OR of all filtered, enabled low and upper cause bits, summary bits included. It changes one clock after the cause or mask registers change.
- R12: Writes to the low cause, upper cause and vector addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_src_i | input | 32 | Low main group source levels |
| hi_src_i | input | 32 | Upper main group source levels (bits 24..27 unused) |
| port_src_i | input | 32 | Port group inputs, edge captured |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Registered level interrupt to the processor |

## Verification
The bench uses the default parameters: 32-bit groups, four summary bits starting at bit 24, and the two filter constants. With these values the numbers 32+k and 64+k and the filter holes at low bits 0, 25, 30 and 31 fall at the exact positions software depends on. A vector table walks through low-group ordering, filtering, masking and upper-group selection. Directed sequences then cover edge capture, summary routing, clear-by-zero with a simultaneous edge, the one-clock latency of the interrupt line and reset values.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

    typedef enum logic [2:0] {
        CIP_LO_CAUSE   = 3'd0,
        CIP_HI_CAUSE   = 3'd1,
        CIP_PORT_CAUSE = 3'd2,
        CIP_LO_MASK    = 3'd3,
        CIP_HI_MASK    = 3'd4,
        CIP_PORT_MASK  = 3'd5,
        CIP_VECTOR     = 3'd6,
        CIP_SPARE      = 3'd7
    } cip_reg_e;

endpackage

// File: rtl/cip_hibit.sv
module cip_hibit #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cip_cause_bank.sv
module cip_cause_bank #(
    parameter int GRP_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [GRP_W-1:0] lo_src_i,
    input  logic [GRP_W-1:0] hi_src_i,
    input  logic [GRP_W-1:0] port_src_i,
    input  logic             port_wr_i,
    input  logic [GRP_W-1:0] port_keep_i,
    output logic [GRP_W-1:0] lo_cause_o,
    output logic [GRP_W-1:0] hi_raw_o,
    output logic [GRP_W-1:0] port_cause_o
);

    typedef struct packed {
        logic [GRP_W-1:0] lo;
        logic [GRP_W-1:0] hi;
        logic [GRP_W-1:0] port;
        logic [GRP_W-1:0] port_prev;
    } cause_st_t;

    cause_st_t st_d, st_q;
    logic [GRP_W-1:0] rise_d;
    logic [GRP_W-1:0] keep_d;

    always_comb begin
        st_d           = st_q;
        rise_d         = port_src_i & ~st_q.port_prev;
        keep_d         = port_wr_i ? port_keep_i : '1;
        st_d.lo        = lo_src_i;
        st_d.hi        = hi_src_i;
        st_d.port_prev = port_src_i;
        st_d.port      = (st_q.port & keep_d) | rise_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_cause_o   = st_q.lo;
    assign hi_raw_o     = st_q.hi;
    assign port_cause_o = st_q.port;

endmodule

// File: rtl/cip_mask_bank.sv
module cip_mask_bank #(
    parameter int               GRP_W  = 32,
    parameter logic [GRP_W-1:0] HI_RST = 32'h0f00_0000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lo_we_i,
    input  logic             hi_we_i,
    input  logic             port_we_i,
    input  logic [GRP_W-1:0] wdata_i,
    output logic [GRP_W-1:0] lo_mask_o,
    output logic [GRP_W-1:0] hi_mask_o,
    output logic [GRP_W-1:0] port_mask_o
);

    typedef struct packed {
        logic [GRP_W-1:0] lo;
        logic [GRP_W-1:0] hi;
        logic [GRP_W-1:0] port;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_we_i) begin
            st_d.lo = wdata_i;
        end
        if (hi_we_i) begin
            st_d.hi = wdata_i;
        end
        if (port_we_i) begin
            st_d.port = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lo   <= '0;
            st_q.hi   <= HI_RST;
            st_q.port <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_mask_o   = st_q.lo;
    assign hi_mask_o   = st_q.hi;
    assign port_mask_o = st_q.port;

endmodule

// File: rtl/cip_vector.sv
module cip_vector #(
    parameter int GRP_W   = 32,
    parameter int VEC_W   = 7,
    parameter int SUM_LSB = 24,
    parameter int SUM_CNT = 4
) (
    input  logic [GRP_W-1:0] lo_eff_i,
    input  logic [GRP_W-1:0] hi_eff_i,
    input  logic [GRP_W-1:0] port_eff_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] num_o
);

    localparam int               IDX_W     = $clog2(GRP_W);
    localparam logic [VEC_W-1:0] BASE_HI   = VEC_W'(GRP_W);
    localparam logic [VEC_W-1:0] BASE_PORT = VEC_W'(2 * GRP_W);
    localparam logic [VEC_W-1:0] BOGUS     = '1;
    localparam logic [IDX_W-1:0] SUM_FIRST = IDX_W'(SUM_LSB);
    localparam logic [IDX_W-1:0] SUM_LAST  = IDX_W'(SUM_LSB + SUM_CNT - 1);

    logic             lo_any, hi_any, port_any;
    logic [IDX_W-1:0] lo_idx, hi_idx, port_idx;

    cip_hibit #(.W(GRP_W), .IDX_W(IDX_W)) i_lo_enc (
        .vec_i(lo_eff_i), .any_o(lo_any), .idx_o(lo_idx)
    );
    cip_hibit #(.W(GRP_W), .IDX_W(IDX_W)) i_hi_enc (
        .vec_i(hi_eff_i), .any_o(hi_any), .idx_o(hi_idx)
    );
    cip_hibit #(.W(GRP_W), .IDX_W(IDX_W)) i_port_enc (
        .vec_i(port_eff_i), .any_o(port_any), .idx_o(port_idx)
    );

    always_comb begin
        valid_o = 1'b0;
        num_o   = BOGUS;
        if (lo_any) begin
            valid_o = 1'b1;
            num_o   = VEC_W'(lo_idx);
        end else if (hi_any) begin
            if (hi_idx >= SUM_FIRST && hi_idx <= SUM_LAST) begin
                if (port_any) begin
                    valid_o = 1'b1;
                    num_o   = BASE_PORT + VEC_W'(port_idx);
                end
            end else begin
                valid_o = 1'b1;
                num_o   = BASE_HI + VEC_W'(hi_idx);
            end
        end
    end

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import casc_irq_pkg::*;
#(
    parameter int               GRP_W       = 32,
    parameter int               VEC_W       = 7,
    parameter int               SUM_LSB     = 24,
    parameter int               SUM_CNT     = 4,
    parameter logic [GRP_W-1:0] LO_FILTER   = 32'h3dff_fffe,
    parameter logic [GRP_W-1:0] HI_FILTER   = 32'h0f00_0db7,
    parameter logic [GRP_W-1:0] HI_MASK_RST = 32'h0f00_0000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [GRP_W-1:0] lo_src_i,
    input  logic [GRP_W-1:0] hi_src_i,
    input  logic [GRP_W-1:0] port_src_i,
    input  logic             reg_we_i,
    input  logic [2:0]       reg_addr_i,
    input  logic [GRP_W-1:0] reg_wdata_i,
    output logic [GRP_W-1:0] reg_rdata_o,
    output logic             irq_o
);

    localparam int               SPAN      = GRP_W / SUM_CNT;
    localparam logic [GRP_W-1:0] SUM_FIELD = GRP_W'(((1 << SUM_CNT) - 1) << SUM_LSB);

    cip_reg_e         addr;
    logic             wr_port_cause, wr_lo_mask, wr_hi_mask, wr_port_mask;
    logic [GRP_W-1:0] lo_cause, hi_raw, hi_cause, port_cause;
    logic [GRP_W-1:0] lo_mask, hi_mask, port_mask;
    logic [GRP_W-1:0] lo_eff, hi_eff, port_eff;
    logic [SUM_CNT-1:0] summ;
    logic             vec_valid;
    logic [VEC_W-1:0] vec_num;
    logic             irq_d, irq_q;

    assign addr          = cip_reg_e'(reg_addr_i);
    assign wr_port_cause = reg_we_i && (addr == CIP_PORT_CAUSE);
    assign wr_lo_mask    = reg_we_i && (addr == CIP_LO_MASK);
    assign wr_hi_mask    = reg_we_i && (addr == CIP_HI_MASK);
    assign wr_port_mask  = reg_we_i && (addr == CIP_PORT_MASK);

    cip_cause_bank #(.GRP_W(GRP_W)) i_cause (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lo_src_i    (lo_src_i),
        .hi_src_i    (hi_src_i),
        .port_src_i  (port_src_i),
        .port_wr_i   (wr_port_cause),
        .port_keep_i (reg_wdata_i),
        .lo_cause_o  (lo_cause),
        .hi_raw_o    (hi_raw),
        .port_cause_o(port_cause)
    );

    cip_mask_bank #(.GRP_W(GRP_W), .HI_RST(HI_MASK_RST)) i_mask (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lo_we_i    (wr_lo_mask),
        .hi_we_i    (wr_hi_mask),
        .port_we_i  (wr_port_mask),
        .wdata_i    (reg_wdata_i),
        .lo_mask_o  (lo_mask),
        .hi_mask_o  (hi_mask),
        .port_mask_o(port_mask)
    );

    for (genvar k = 0; k < SUM_CNT; k++) begin : g_summary
        assign summ[k] = |port_cause[k*SPAN +: SPAN];
    end

    assign hi_cause = (hi_raw & ~SUM_FIELD) | (GRP_W'(summ) << SUM_LSB);
    assign lo_eff   = lo_cause & lo_mask & LO_FILTER;
    assign hi_eff   = hi_cause & hi_mask & HI_FILTER;
    assign port_eff = port_cause & port_mask;

    cip_vector #(
        .GRP_W(GRP_W), .VEC_W(VEC_W), .SUM_LSB(SUM_LSB), .SUM_CNT(SUM_CNT)
    ) i_vector (
        .lo_eff_i  (lo_eff),
        .hi_eff_i  (hi_eff),
        .port_eff_i(port_eff),
        .valid_o   (vec_valid),
        .num_o     (vec_num)
    );

    always_comb begin
        irq_d = (|lo_eff) | (|hi_eff);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        case (addr)
            CIP_LO_CAUSE:   reg_rdata_o = lo_cause;
            CIP_HI_CAUSE:   reg_rdata_o = hi_cause;
            CIP_PORT_CAUSE: reg_rdata_o = port_cause;
            CIP_LO_MASK:    reg_rdata_o = lo_mask;
            CIP_HI_MASK:    reg_rdata_o = hi_mask;
            CIP_PORT_MASK:  reg_rdata_o = port_mask;
            CIP_VECTOR:     reg_rdata_o = {{(GRP_W-VEC_W-1){1'b0}}, vec_valid, vec_num};
            default:        reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/cip_checker.sv
module cip_checker #(
    parameter int GRP_W = 32,
    parameter int VEC_W = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [GRP_W-1:0] lo_src_i,
    input logic             reg_we_i,
    input logic [2:0]       reg_addr_i,
    input logic [GRP_W-1:0] lo_cause,
    input logic [GRP_W-1:0] port_cause,
    input logic [GRP_W-1:0] lo_eff,
    input logic [GRP_W-1:0] hi_eff,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_num,
    input logic             irq_o
);

    localparam int IDX_W = $clog2(GRP_W);

    AST_LO_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (lo_cause == $past(lo_src_i))); // R2

    AST_VEC_LO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid && (vec_num < VEC_W'(GRP_W))) |-> lo_eff[vec_num[IDX_W-1:0]]); // R3

    AST_LO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|lo_eff) |-> (vec_valid && (vec_num < VEC_W'(GRP_W)))); // R5

    AST_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_we_i && (reg_addr_i == 3'd2)) |=>
        ((port_cause & $past(port_cause)) == $past(port_cause))); // R7

    AST_NONE_BOGUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(|lo_eff) && !(|hi_eff)) |-> !vec_valid); // R9

    AST_IRQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past((|lo_eff) || (|hi_eff)))); // R11

endmodule

bind casc_irq_ctrl cip_checker #(.GRP_W(GRP_W), .VEC_W(VEC_W)) i_cip_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lo_src_i  (lo_src_i),
    .reg_we_i  (reg_we_i),
    .reg_addr_i(reg_addr_i),
    .lo_cause  (lo_cause),
    .port_cause(port_cause),
    .lo_eff    (lo_eff),
    .hi_eff    (hi_eff),
    .vec_valid (vec_valid),
    .vec_num   (vec_num),
    .irq_o     (irq_o)
);

// File: tb/test_casc_irq_ctrl.sv
`timescale 1ns/1ps
module test_casc_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lo_src = '0, hi_src = '0, port_src = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    casc_irq_ctrl i_casc_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .lo_src_i(lo_src), .hi_src_i(hi_src), .port_src_i(port_src),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] lo_mask;
        logic [31:0] hi;
        logic [31:0] hi_mask;
        logic [7:0]  vec;
        logic        irq;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t TABLE [NROWS] = '{
        '{32'h0000_0010, 32'hffff_ffff, 32'h0,         32'h0,         8'h84, 1'b1}, // R3
        '{32'h0000_0112, 32'hffff_ffff, 32'h0,         32'h0,         8'h88, 1'b1}, // R3
        '{32'h8000_0001, 32'hffff_ffff, 32'h0,         32'h0,         8'h7f, 1'b0}, // R4
        '{32'h0200_0000, 32'hffff_ffff, 32'h0,         32'h0,         8'h7f, 1'b0}, // R4
        '{32'h0000_0100, 32'h0000_00ff, 32'h0,         32'h0,         8'h7f, 1'b0}, // R3 mask
        '{32'h0,         32'h0,         32'h0000_0081, 32'hffff_ffff, 8'ha7, 1'b1}, // R6
        '{32'h0,         32'h0,         32'h0000_0808, 32'hffff_ffff, 8'hab, 1'b1}, // R6
        '{32'h0,         32'h0,         32'h0000_0040, 32'hffff_ffff, 8'h7f, 1'b0}, // R4
        '{32'h0000_0002, 32'hffff_ffff, 32'h0000_0800, 32'hffff_ffff, 8'h81, 1'b1}, // R5
        '{32'h0,         32'h0,         32'h0f00_0000, 32'hffff_ffff, 8'h7f, 1'b0}, // R8
        '{32'h0,         32'h0,         32'h0000_1000, 32'hffff_ffff, 8'h7f, 1'b0}, // R4
        '{32'h2000_0000, 32'hffff_ffff, 32'h0,         32'h0,         8'h9d, 1'b1}  // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        for (int r = 0; r < NROWS; r++) begin
            wr(3'd3, TABLE[r].lo_mask);
            wr(3'd4, TABLE[r].hi_mask);
            lo_src = TABLE[r].lo;
            hi_src = TABLE[r].hi;
            tick();
            tick();
            rd(3'd6, v);
            check($sformatf("R3/R4/R5/R6 row %0d vector", r), v, {24'h0, TABLE[r].vec});
            check($sformatf("R4/R11 row %0d irq", r), {31'h0, irq}, {31'h0, TABLE[r].irq});
        end

        lo_src = '0; hi_src = '0;
        do_reset();
        // R1 reset values
        rd(3'd0, v); check("R1 low cause", v, 32'h0);
        rd(3'd1, v); check("R1 upper cause", v, 32'h0);
        rd(3'd2, v); check("R1 port cause", v, 32'h0);
        rd(3'd3, v); check("R1 low mask", v, 32'h0);
        rd(3'd4, v); check("R1 upper mask", v, 32'h0f00_0000);
        rd(3'd5, v); check("R1 port mask", v, 32'h0);
        rd(3'd6, v); check("R1 vector", v, 32'h0000_007f);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R12 read-only addresses
        wr(3'd0, 32'hffff_ffff); rd(3'd0, v); check("R12 low cause write", v, 32'h0);
        wr(3'd1, 32'hffff_ffff); rd(3'd1, v); check("R12 upper cause write", v, 32'h0);
        wr(3'd6, 32'h0000_0085); rd(3'd6, v); check("R12 vector write", v, 32'h0000_007f);

        // R2 level capture timing
        lo_src = 32'h0000_0040;
        rd(3'd0, v); check("R2 before edge", v, 32'h0);
        tick();
        rd(3'd0, v); check("R2 after edge", v, 32'h0000_0040);
        lo_src = '0;
        tick();

        // R7/R8/R9 port capture and summary
        port_src[9] = 1'b1;
        tick();
        port_src[9] = 1'b0;
        rd(3'd2, v); check("R7 port edge set", v, 32'h0000_0200);
        rd(3'd1, v); check("R8 summary bit 25", v, 32'h0200_0000);
        rd(3'd6, v); check("R9 summary without enabled port", v, 32'h0000_007f);
        check("R11 irq not yet", {31'h0, irq}, 32'h0);
        tick();
        check("R11 irq from summary", {31'h0, irq}, 32'h1);
        rd(3'd2, v); check("R7 held after input fell", v, 32'h0000_0200);
        wr(3'd5, 32'hffff_ffff);
        rd(3'd6, v); check("R8 port vector 73", v, 32'h0000_00c9);

        port_src[3] = 1'b1;
        tick();
        port_src[3] = 1'b0;
        rd(3'd2, v); check("R7 second port bit", v, 32'h0000_0208);
        rd(3'd6, v); check("R8 highest port wins", v, 32'h0000_00c9);

        // R10 clear by zero
        wr(3'd2, ~32'h0000_0200);
        rd(3'd2, v); check("R10 clear one bit", v, 32'h0000_0008);
        rd(3'd6, v); check("R8 port vector 67", v, 32'h0000_00c3);
        rd(3'd1, v); check("R8 summary bit 24", v, 32'h0100_0000);

        port_src[20] = 1'b1;
        wr(3'd2, 32'hffef_ffff);
        rd(3'd2, v); check("R10 edge wins over clear", v, 32'h0010_0008);
        rd(3'd6, v); check("R8 port vector 84", v, 32'h0000_00d4);
        rd(3'd1, v); check("R8 summary bits 24 and 26", v, 32'h0500_0000);

        wr(3'd2, 32'h0);
        rd(3'd2, v); check("R10 clear all", v, 32'h0);
        check("R11 irq held one clock", {31'h0, irq}, 32'h1);
        tick();
        check("R11 irq drops", {31'h0, irq}, 32'h0);
        rd(3'd6, v); check("R9 nothing pending", v, 32'h0000_007f);
        port_src[20] = 1'b0;

        // R11 mask write latency
        lo_src = 32'h0000_0010;
        tick();
        tick();
        check("R11 masked source", {31'h0, irq}, 32'h0);
        wr(3'd3, 32'h0000_0010);
        check("R11 irq before mask latency", {31'h0, irq}, 32'h0);
        tick();
        check("R11 irq after mask latency", {31'h0, irq}, 32'h1);
        rd(3'd6, v); check("R3 vector 4", v, 32'h0000_0084);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule